// File: doc/BRIEF.md
# Watchdog Timer with Power-LED Blinker

This block is a host-programmable watchdog. The host writes a reload value, a configuration byte and a control byte through a small synchronous register port. A down-counter is clocked by a one-second tick, which an internal prescaler derives from the system clock. When the counter runs out, the block raises a time-out status flag. Any of three system-event inputs can restart the countdown, provided the host has enabled that event. The host can also force a time-out or clear the status.

The status flag drives three outputs:
- an interrupt request, which is gated by an enable bit;
- a general-purpose time-out pin with selectable polarity;
- a power-LED driver.

The LED either stays steadily asserted or blinks at 1 Hz with 50% duty. It blinks on host command, or while a time-out is pending if the host has asked for that. Its active level is selectable.

Top module: `wdog_led_top`

Register map (2-bit address):
- 0: reload value.
- 1: configuration.
  - bits [2:0] enable events 0..2.
  - bit 3 blinks the LED on time-out.
  - bit 4 enables the interrupt.
  - bit 5 inverts the time-out pin.
  - bit 6 makes the LED active-high.
  - bit 7 reads 0.
- 2: control.
  - bit 0 is the status flag. It reads back the flag, and writing 1 clears it.
  - bit 1 forces blinking.
  - bit 2 forces a time-out. It is self-clearing and reads 0.
- 3: reads 0.

## Requirements
- R1: After reset all three registers read 0, the count is 0, the status flag is 0, `irq` is 0, `wdt_pin` is 0, and `led_out` is 0 (steady asserted at the default active-low level).
- R2: Writing address 0 stores the reload value and loads it into the count. The count then drops by one on each one-second tick (every 2·HALF_SEC_CLKS clocks) while it is nonzero. On the step from 1 to 0 the status flag sets, and the count then stays at 0. With every event disabled, nothing stops this.
- R3: While the count is 0 and no write or event touches it, the count stays 0 and the status flag keeps its value. A reload value of 0 therefore never times out.
- R4: When system event k is high and configuration bit k is 1, the count is reloaded from address 0 and the status flag clears. A high event whose enable bit is 0 has no effect.
- R5: Writing 1 to control bit 2 zeroes the count and sets the status flag. This wins over an event or a status-clear in the same cycle. Bit 2 always reads 0.
- R6: Writing 1 to control bit 0 clears the status flag, unless the count expires or a forced time-out occurs in that same cycle.
- R7: `irq` equals the status flag when configuration bit 4 is 1, and is 0 otherwise. It therefore rises with the flag.
- R8: `wdt_pin` equals the status flag when configuration bit 5 is 0, and the inverted flag when it is 1.
- R9: The LED blinks when control bit 1 is 1, or when configuration bit 3 and the status flag are both 1. In every other case it is steadily asserted.
- R10: While blinking, the LED's asserted phase toggles every HALF_SEC_CLKS clocks. This gives a 1 Hz, 50% duty waveform, and the waveform starts in the asserted phase.
- R11: `led_out` drives the asserted level low when configuration bit 6 is 0, and high when it is 1.
- R12: Reads return the reload value, configuration bits [6:0] with bit 7 as 0, and control as {5'b0, 0, blink bit, status}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sys_evt | input | 3 | System-event inputs, active high |
| irq | output | 1 | Interrupt request |
| wdt_pin | output | 1 | Polarity-selectable time-out output |
| led_out | output | 1 | Power-LED drive |

## Verification
The assertions assume that the event inputs and register writes are synchronous to the clock, and that there is at most one register write per cycle. They also assume that the prescaler's half-second pulse lasts a single cycle. The assertions that check decrement and reload use `$past` only one cycle deep, so they rely on no write landing in the cycle they observe. The bench drives every input just after the falling edge and holds it for a full cycle. Where a scenario needs collisions (a force together with an event, or a clear together with expiry), it creates them only as one deliberate write in one cycle.

// File: rtl/wdog_pkg.sv
// Package: shared register addresses, field positions and the configuration
// record of the watchdog. Assumes an 8-bit register data path.
package wdog_pkg;

    localparam int DATA_W = 8;
    localparam int N_EVT  = 3;

    localparam logic [1:0] ADDR_RELOAD = 2'd0;
    localparam logic [1:0] ADDR_CFG    = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CTRL_STATUS = 0;
    localparam int CTRL_BLINK  = 1;
    localparam int CTRL_FORCE  = 2;

    // Configuration record, packed so bit k of the record is bit k of the register.
    typedef struct packed {
        logic             led_hi;    // bit 6
        logic             pin_inv;   // bit 5
        logic             irq_en;    // bit 4
        logic             led_on_to; // bit 3
        logic [N_EVT-1:0] evt_en;    // bits 2:0
    } wd_cfg_t;

    localparam int CFG_W = $bits(wd_cfg_t);

endpackage

// File: rtl/wdog_prescaler.sv
// Prescaler: divides the system clock into a one-cycle half-second pulse and
// a one-cycle one-second tick (every second half pulse). Assumes HALF_CLKS >= 2.
module wdog_prescaler #(
    parameter int HALF_CLKS = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic half_pulse,
    output logic sec_tick
);
    localparam int PW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF_CLKS - 1);

    logic [PW-1:0] div_q;
    logic          sec_ph_q;

    assign half_pulse = (div_q == LAST);
    assign sec_tick   = half_pulse & sec_ph_q;

    // Free-running divider and second-phase flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            sec_ph_q <= 1'b0;
        end else if (half_pulse) begin
            div_q    <= '0;
            sec_ph_q <= ~sec_ph_q;
        end else begin
            div_q    <= div_q + 1'b1;
        end
    end

    a_r10_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |=> !half_pulse);

endmodule

// File: rtl/wdog_regs.sv
// Register file: holds reload, configuration and blink control, decodes the
// self-clearing write actions and muxes read data. Assumes one write per cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              status,
    output logic [CNT_W-1:0]  reload_q,
    output wd_cfg_t           cfg_q,
    output logic              blink_q,
    output logic              reload_wr,
    output logic [CNT_W-1:0]  reload_new,
    output logic              force_req,
    output logic              clr_req
);
    logic ctrl_wr;

    assign ctrl_wr    = reg_wr && (reg_addr == ADDR_CTRL);
    assign reload_wr  = reg_wr && (reg_addr == ADDR_RELOAD);
    assign reload_new = reg_wdata[CNT_W-1:0];
    assign force_req  = ctrl_wr && reg_wdata[CTRL_FORCE];
    assign clr_req    = ctrl_wr && reg_wdata[CTRL_STATUS];

    // Storage for the host-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cfg_q    <= '0;
            blink_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_RELOAD: reload_q <= reload_new;
                ADDR_CFG:    cfg_q    <= wd_cfg_t'(reg_wdata[CFG_W-1:0]);
                ADDR_CTRL:   blink_q  <= reg_wdata[CTRL_BLINK];
                default:     ;
            endcase
        end
    end

    // Read-data mux; the force bit is never stored so it reads zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_RELOAD: reg_rdata[CNT_W-1:0] = reload_q;
            ADDR_CFG:    reg_rdata[CFG_W-1:0] = cfg_q;
            ADDR_CTRL: begin
                reg_rdata[CTRL_STATUS] = status;
                reg_rdata[CTRL_BLINK]  = blink_q;
            end
            default:     reg_rdata = '0;
        endcase
    end

    a_r12_reload_store: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> reload_q == $past(reload_new));

endmodule

// File: rtl/wdog_counter.sv
// Countdown core: keeps the count and the time-out status flag. Priority per
// cycle: forced time-out, then enabled event reload, then host write/tick.
// Assumes sec_tick is a single-cycle pulse.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [N_EVT-1:0] sys_evt,
    input  logic [N_EVT-1:0] evt_en,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_new,
    input  logic             force_req,
    input  logic             clr_req,
    output logic             status_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             evt_hit;
    logic             expire;

    assign evt_hit = |(sys_evt & evt_en);
    assign expire  = sec_tick && (cnt_q == ONE) && !reload_wr;

    // Count and status update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            status_q <= 1'b0;
        end else if (force_req) begin
            cnt_q    <= '0;
            status_q <= 1'b1;
        end else if (evt_hit) begin
            cnt_q    <= reload_q;
            status_q <= 1'b0;
        end else begin
            if (reload_wr)
                cnt_q <= reload_new;
            else if (sec_tick && (cnt_q != '0))
                cnt_q <= cnt_q - ONE;
            if (expire)
                status_q <= 1'b1;
            else if (clr_req)
                status_q <= 1'b0;
        end
    end

    a_r5_force_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        force_req |=> status_q && (cnt_q == '0));

    a_r4_event_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && !force_req) |=> (cnt_q == $past(reload_q)) && !status_q);

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (cnt_q > ONE) && !force_req && !evt_hit && !reload_wr)
        |=> cnt_q == $past(cnt_q) - ONE);

    a_r2_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (cnt_q == ONE) && !force_req && !evt_hit && !reload_wr)
        |=> status_q && (cnt_q == '0));

    a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '0) && !force_req && !evt_hit && !reload_wr && !clr_req)
        |=> (cnt_q == '0) && $stable(status_q));

endmodule

// File: rtl/wdog_led.sv
// LED driver: decides between steady and blinking drive, keeps the blink
// phase flop (restarted asserted) and applies the output polarity.
// Assumes half_pulse is a single-cycle pulse every half second.
module wdog_led (
    input  logic clk,
    input  logic rst_n,
    input  logic half_pulse,
    input  logic blink_cmd,
    input  logic led_on_to,
    input  logic status,
    input  logic led_hi,
    output logic led_out
);
    logic blink;
    logic phase_q;
    logic asserted;

    assign blink    = blink_cmd | (led_on_to & status);
    assign asserted = blink ? phase_q : 1'b1;
    assign led_out  = led_hi ? asserted : ~asserted;

    // Blink phase: held asserted while steady, toggled each half second.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b1;
        else if (!blink)
            phase_q <= 1'b1;
        else if (half_pulse)
            phase_q <= ~phase_q;
    end

    a_r10_blink_starts_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blink) |-> phase_q);

    a_r10_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (blink && !half_pulse) |=> $stable(phase_q));

endmodule

// File: rtl/wdog_led_top.sv
// Top: ties prescaler, register file, countdown core and LED driver together
// and forms the interrupt and time-out pin outputs from the status flag.
module wdog_led_top
    import wdog_pkg::*;
#(
    parameter int HALF_SEC_CLKS = 25_000_000,
    parameter int CNT_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  sys_evt,
    output logic              irq,
    output logic              wdt_pin,
    output logic              led_out
);
    logic             half_pulse;
    logic             sec_tick;
    logic             status;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] reload_new;
    wd_cfg_t          cfg_q;
    logic             blink_q;
    logic             reload_wr;
    logic             force_req;
    logic             clr_req;

    wdog_prescaler #(.HALF_CLKS(HALF_SEC_CLKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .half_pulse(half_pulse), .sec_tick(sec_tick)
    );

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status),
        .reload_q(reload_q), .cfg_q(cfg_q), .blink_q(blink_q),
        .reload_wr(reload_wr), .reload_new(reload_new),
        .force_req(force_req), .clr_req(clr_req)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sys_evt(sys_evt),
        .evt_en(cfg_q.evt_en), .reload_q(reload_q), .reload_wr(reload_wr),
        .reload_new(reload_new), .force_req(force_req), .clr_req(clr_req),
        .status_q(status)
    );

    wdog_led u_led (
        .clk(clk), .rst_n(rst_n), .half_pulse(half_pulse), .blink_cmd(blink_q),
        .led_on_to(cfg_q.led_on_to), .status(status), .led_hi(cfg_q.led_hi),
        .led_out(led_out)
    );

    assign irq     = cfg_q.irq_en & status;
    assign wdt_pin = status ^ cfg_q.pin_inv;

    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status) && cfg_q.irq_en) |-> irq);

endmodule

// File: tb/sim_wdog_led_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the outputs on every falling edge, plus directed checks.
module sim_wdog_led_top;
    localparam int PERIOD = 10;
    localparam int HALF   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [2:0] sys_evt = 3'd0;
    logic       irq, wdt_pin, led_out;

    int errors = 0;
    int checks = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // Reference model state
    int m_cnt = 0, m_st = 0, m_reload = 0, m_cfg = 0, m_blk = 0;
    int m_pre = 0, m_secph = 0, m_ph = 1;

    wdog_led_top #(.HALF_SEC_CLKS(HALF), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_evt(sys_evt),
        .irq(irq), .wdt_pin(wdt_pin), .led_out(led_out)
    );

    always #(PERIOD/2) clk = ~clk;

    // Model update on each rising edge from the inputs held across it.
    always @(posedge clk) begin
        int half, tick, blink, force_w, clr_w, rl_w, hit, n_cnt, n_st, n_ph;
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_reload = 0; m_cfg = 0; m_blk = 0;
            m_pre = 0; m_secph = 0; m_ph = 1;
        end else begin
            half    = (m_pre == HALF - 1);
            tick    = half && m_secph;
            blink   = m_blk || (((m_cfg >> 3) & 1) && m_st);
            force_w = reg_wr && reg_addr == 2 && reg_wdata[2];
            clr_w   = reg_wr && reg_addr == 2 && reg_wdata[0];
            rl_w    = reg_wr && reg_addr == 0;
            hit     = ((sys_evt & m_cfg[2:0]) != 0);
            n_cnt = m_cnt; n_st = m_st;
            if (force_w) begin n_cnt = 0; n_st = 1; end
            else if (hit) begin n_cnt = m_reload; n_st = 0; end
            else begin
                if (rl_w) n_cnt = reg_wdata;
                else if (tick && m_cnt > 0) n_cnt = m_cnt - 1;
                if (tick && m_cnt == 1 && !rl_w) n_st = 1;
                else if (clr_w) n_st = 0;
            end
            n_ph = !blink ? 1 : (half ? !m_ph : m_ph);
            if (reg_wr && reg_addr == 0) m_reload = reg_wdata;
            if (reg_wr && reg_addr == 1) m_cfg = reg_wdata & 8'h7f;
            if (reg_wr && reg_addr == 2) m_blk = reg_wdata[1];
            m_cnt = n_cnt; m_st = n_st; m_ph = n_ph;
            if (half) begin m_pre = 0; m_secph = !m_secph; end
            else m_pre = m_pre + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_led();
        int blink, as;
        blink = m_blk || (((m_cfg >> 3) & 1) && m_st);
        as = blink ? m_ph : 1;
        return ((m_cfg >> 6) & 1) ? as : !as;
    endfunction

    // One clock: wait for falling edge and compare outputs with the model.
    task automatic cyc();
        @(negedge clk);
        if (armed) begin
            chk("R7 irq", irq, ((m_cfg >> 4) & 1) & m_st);
            chk("R8 wdt_pin", wdt_pin, m_st ^ ((m_cfg >> 5) & 1));
            chk("R9/R10/R11 led_out", led_out, exp_led());
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse_evt(input logic [2:0] e);
        sys_evt = e;
        cyc();
        sys_evt = 3'd0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Count asserted (high) LED cycles over a 4*HALF window.
    task automatic high_count(input string req);
        int hi = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            cyc();
            hi += led_out;
        end
        chk(req, hi, 2 * HALF);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        cyc();
        armed = 1'b1;
        // R1 reset state
        rd(2'd0, 0, "R1 reload"); rd(2'd1, 0, "R1 cfg"); rd(2'd2, 0, "R1 ctrl");
        chk("R1 led", led_out, 0); chk("R1 irq", irq, 0); chk("R1 pin", wdt_pin, 0);

        // R2 countdown with all events disabled, irq enabled
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd0, 8'd3);
        run(8 * HALF);
        rd(2'd2, 8'h01, "R2 expired status");
        chk("R7 irq high", irq, 1);

        // R4 disabled event ignored, then enabled event reloads
        pulse_evt(3'b001);
        rd(2'd2, 8'h01, "R4 disabled event ignored");
        wr_reg(2'd1, 8'h15);
        pulse_evt(3'b001);
        rd(2'd2, 8'h00, "R4 event clears status");
        run(10);
        rd(2'd2, 8'h00, "R4 reloaded count still running");
        for (int k = 0; k < 8; k++) begin
            pulse_evt(3'b100);
            run(8);
        end
        rd(2'd2, 8'h00, "R4 events keep watchdog alive");
        pulse_evt(3'b010);
        run(8 * HALF);
        rd(2'd2, 8'h01, "R4 unenabled event 1 no effect");

        // R5 force, R6 clear, force beats event
        wr_reg(2'd2, 8'h01);
        rd(2'd2, 8'h00, "R6 clear");
        wr_reg(2'd2, 8'h04);
        rd(2'd2, 8'h01, "R5 force sets status, bit2 reads 0");
        wr_reg(2'd2, 8'h01);
        sys_evt = 3'b001;
        wr_reg(2'd2, 8'h04);
        sys_evt = 3'd0;
        rd(2'd2, 8'h01, "R5 force beats event");
        wr_reg(2'd2, 8'h05);
        rd(2'd2, 8'h01, "R5 force beats clear");

        // R8 and R11 polarity
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd1, 8'h31);
        chk("R8 inverted pin", wdt_pin, 1);
        wr_reg(2'd1, 8'h71);
        chk("R11 active-high led", led_out, 1);

        // R9/R10 host blink
        wr_reg(2'd2, 8'h02);
        chk("R10 blink starts asserted", led_out, 1);
        high_count("R10 50% duty (host blink)");
        rd(2'd2, 8'h02, "R12 ctrl blink readback");
        wr_reg(2'd2, 8'h00);
        run(2);
        chk("R9 steady after blink off", led_out, 1);

        // R9 blink on pending time-out
        wr_reg(2'd1, 8'h78);
        wr_reg(2'd2, 8'h04);
        high_count("R9 blink on time-out");
        wr_reg(2'd2, 8'h01);
        run(2 * HALF);
        chk("R9 steady once cleared", led_out, 1);

        // R3 reload zero never expires
        wr_reg(2'd1, 8'h10);
        wr_reg(2'd0, 8'd0);
        run(12 * HALF);
        rd(2'd2, 8'h00, "R3 zero reload no time-out");
        wr_reg(2'd2, 8'h04);
        wr_reg(2'd0, 8'd0);
        run(6 * HALF);
        rd(2'd2, 8'h01, "R3 status kept at zero count");

        // R2 short reload with no events
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd0, 8'd1);
        run(4 * HALF + 1);
        rd(2'd2, 8'h01, "R2 reload 1 expires");

        // R12 readback
        rd(2'd0, 8'h01, "R12 reload readback");
        wr_reg(2'd1, 8'hff);
        rd(2'd1, 8'h7f, "R12 cfg bit7 reads 0");
        rd(2'd3, 8'h00, "R12 unused address");
        run(4);
        report();
    end
endmodule